// File: doc/BRIEF.md
# Forced-Opcode CPU Register Readout Sequencer

This debug block reads the internal registers of a 65xx-family CPU that has no debug support of its own. On a host command it waits for the next opcode fetch and then, on every program fetch, replaces the memory data with the bytes of a short position-independent routine. The routine is push flags, pull flags, store A to direct page $02, store X to absolute $4440, store Y to direct page $06, and a relative branch of -11 back to the starting address. While the routine runs, every CPU write is blocked, so memory is never altered. The block watches the bus trace and rebuilds the register file from it.

The captured values are as follows. PC and program bank come from the first opcode fetch. The stack pointer and the status byte come from the push write. A, X and Y come from the store writes. The direct register is the store-A address minus two. The data bank is the bank of the store-X write. The E, M and X pins decide whether a store has a second write carrying the high byte. When the branch offset has been fetched, `done` rises and the results hold until the next accepted command.

The bus side is sampled once per CPU cycle through `cyc_vld`. The override and write-inhibit outputs are combinational on the current cycle's qualifiers, so they act within that cycle.

Top module: `regread_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `done`=0, all result outputs 0, `ovr_en`=0 and `wr_inh`=0. A `cmd_start` pulse while idle or done sets `busy`=1 and `done`=0 on the next clock.
- R2: Once armed, the first cycle with `cyc_vld`, `cpu_vpa`, `cpu_vda` and `cpu_rwb` all 1 begins the injection. That cycle and each following cycle with `cyc_vld`, `cpu_vpa` and `cpu_rwb` all 1 assert `ovr_en`. In those cycles `ovr_data` takes, in order, 08 28 85 02 8E 40 44 84 06 80 F5 (hex). `ovr_data` is 00 whenever `ovr_en` is 0.
- R3: Cycles with `cpu_vpa`=0 are never overridden. After the eleventh byte no cycle is overridden, including the next opcode fetch.
- R4: `wr_inh` is 1 during every write cycle (`cpu_rwb`=0) between the first injected fetch and the eleventh, and 0 at all other times.
- R5: `res_pc` and `res_pbr` equal the address and bank of the first injected opcode fetch.
- R6: The first write of the run gives `res_sp` (its address) and `res_p` (its data). `res_emu` gives the `cpu_e` pin level in that cycle.
- R7: The first write of the store-A instruction gives the low byte of `res_a`, and its address minus 2 gives `res_d`. A second write gives the high byte when `cpu_e`=0 and `cpu_m`=0; otherwise the high byte is 00.
- R8: The first write of the store-X instruction gives the low byte of `res_x`, and its bank gives `res_dbr`. A second write gives the high byte when `cpu_e`=0 and `cpu_x`=0; otherwise the high byte is 00.
- R9: The store-Y writes give `res_y` under the same width rule as X.
- R10: `done` rises on the clock of the eleventh injected byte and `busy` falls there. `cmd_start` during a run is ignored. After `done`, further bus cycles change no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Readout command pulse |
| cyc_vld | input | 1 | Bus inputs carry a CPU cycle this clock |
| cpu_addr | input | ADDR_W | CPU address bus |
| cpu_bank | input | BANK_W | CPU bank address |
| cpu_din | input | DATA_W | Data driven by CPU on writes |
| cpu_rwb | input | 1 | 1 = read, 0 = write |
| cpu_vpa | input | 1 | Program address valid |
| cpu_vda | input | 1 | Data address valid |
| cpu_e | input | 1 | Emulation mode pin |
| cpu_m | input | 1 | Accumulator width pin |
| cpu_x | input | 1 | Index width pin |
| ovr_en | output | 1 | Drive `ovr_data` onto the CPU data bus |
| ovr_data | output | DATA_W | Injected instruction byte |
| wr_inh | output | 1 | Suppress the memory write strobe |
| busy | output | 1 | Armed or injecting |
| done | output | 1 | Results complete |
| res_pc | output | ADDR_W | Program counter |
| res_pbr | output | BANK_W | Program bank |
| res_sp | output | ADDR_W | Stack pointer |
| res_p | output | DATA_W | Status flags |
| res_emu | output | 1 | Emulation mode at capture |
| res_a | output | 2*DATA_W | Accumulator |
| res_x | output | 2*DATA_W | X index |
| res_y | output | 2*DATA_W | Y index |
| res_dbr | output | BANK_W | Data bank |
| res_d | output | ADDR_W | Direct register |

## Verification
Two functions can fall in the same cycle: substituting the final branch-offset byte and ending the run. On that edge the block must still override the fetch, close the run and raise `done`, and the very next opcode fetch must reach memory untouched. The bench also lands a stray `cmd_start` in the middle of a run, together with write cycles that must be both inhibited and captured. A cycle-level reference model drives emulation, fully wide native and mixed-width cases. It judges `ovr_en`, `ovr_data` and `wr_inh` on every clock, and all results once `done` is seen.

// File: rtl/regread_pkg.sv
package regread_pkg;

  localparam int SEQ_LEN   = 11;
  localparam int SEQ_IDX_W = $clog2(SEQ_LEN);

  typedef logic [SEQ_IDX_W-1:0] seq_idx_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_RUN,
    ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    ROLE_NONE,
    ROLE_FLAGS,
    ROLE_ACC,
    ROLE_XREG,
    ROLE_YREG
  } wr_role_e;

  // Injected routine: PHP; PLP; STA dp $02; STX abs $4440; STY dp $06; BRA -11
  function automatic logic [7:0] seq_byte(input seq_idx_t i);
    case (i)
      seq_idx_t'(0):  return 8'h08;
      seq_idx_t'(1):  return 8'h28;
      seq_idx_t'(2):  return 8'h85;
      seq_idx_t'(3):  return 8'h02;
      seq_idx_t'(4):  return 8'h8E;
      seq_idx_t'(5):  return 8'h40;
      seq_idx_t'(6):  return 8'h44;
      seq_idx_t'(7):  return 8'h84;
      seq_idx_t'(8):  return 8'h06;
      seq_idx_t'(9):  return 8'h80;
      seq_idx_t'(10): return 8'hF5;
      default:        return 8'hEA;
    endcase
  endfunction

  // Which captured register a write belongs to, from the count of program
  // bytes fetched so far: a write follows all bytes of its own instruction.
  function automatic wr_role_e role_of(input seq_idx_t fetched);
    case (fetched)
      seq_idx_t'(1): return ROLE_FLAGS;
      seq_idx_t'(4): return ROLE_ACC;
      seq_idx_t'(7): return ROLE_XREG;
      seq_idx_t'(9): return ROLE_YREG;
      default:       return ROLE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/regread_fetch_ctl.sv
module regread_fetch_ctl
  import regread_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cyc_vld,
  input  logic              cpu_rwb,
  input  logic              cpu_vpa,
  input  logic              cpu_vda,
  output logic              ovr_en,
  output logic [DATA_W-1:0] ovr_data,
  output logic              wr_inh,
  output logic              busy,
  output logic              done,
  output logic              arm,
  output logic              first_fetch,
  output wr_role_e          wr_role,
  output logic              wr_hi
);

  seq_state_e st;
  seq_idx_t   idx;
  logic       hi_pend;

  logic prog_rd, op_rd, wr_cyc, take;

  assign prog_rd     = cyc_vld & cpu_vpa & cpu_rwb;
  assign op_rd       = prog_rd & cpu_vda;
  assign wr_cyc      = cyc_vld & ~cpu_rwb & (st == ST_RUN);
  assign first_fetch = (st == ST_ARMED) & op_rd;
  assign take        = first_fetch | ((st == ST_RUN) & prog_rd);
  assign arm         = cmd_start & ((st == ST_IDLE) | (st == ST_DONE));

  assign ovr_en   = take;
  assign ovr_data = take ? DATA_W'(seq_byte(idx)) : '0;
  assign wr_inh   = (st == ST_RUN) & ~cpu_rwb;
  assign busy     = (st == ST_ARMED) | (st == ST_RUN);
  assign done     = (st == ST_DONE);
  assign wr_role  = wr_cyc ? role_of(idx) : ROLE_NONE;
  assign wr_hi    = hi_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      idx     <= '0;
      hi_pend <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (cmd_start) begin
            st      <= ST_ARMED;
            idx     <= '0;
            hi_pend <= 1'b0;
          end
        end
        ST_ARMED: begin
          if (op_rd) begin
            st  <= ST_RUN;
            idx <= seq_idx_t'(1);
          end
        end
        ST_RUN: begin
          if (prog_rd) begin
            hi_pend <= 1'b0;
            if (idx == seq_idx_t'(SEQ_LEN - 1)) begin
              st  <= ST_DONE;
              idx <= '0;
            end else begin
              idx <= idx + seq_idx_t'(1);
            end
          end else if (wr_cyc) begin
            hi_pend <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/regread_capture.sv
module regread_capture
  import regread_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                arm,
  input  logic                first_fetch,
  input  wr_role_e            wr_role,
  input  logic                wr_hi,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [BANK_W-1:0]   cpu_bank,
  input  logic [DATA_W-1:0]   cpu_din,
  input  logic                cpu_e,
  input  logic                cpu_m,
  input  logic                cpu_x,
  output logic [ADDR_W-1:0]   res_pc,
  output logic [BANK_W-1:0]   res_pbr,
  output logic [ADDR_W-1:0]   res_sp,
  output logic [DATA_W-1:0]   res_p,
  output logic                res_emu,
  output logic [2*DATA_W-1:0] res_a,
  output logic [2*DATA_W-1:0] res_x,
  output logic [2*DATA_W-1:0] res_y,
  output logic [BANK_W-1:0]   res_dbr,
  output logic [ADDR_W-1:0]   res_d
);

  localparam int REG_W   = 2 * DATA_W;
  localparam int N_IREGS = 3;
  localparam logic [ADDR_W-1:0] DP_OFS = ADDR_W'(2);

  logic [REG_W-1:0] ireg [N_IREGS];

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      res_pc  <= '0;
      res_pbr <= '0;
      res_sp  <= '0;
      res_p   <= '0;
      res_emu <= 1'b0;
      res_dbr <= '0;
      res_d   <= '0;
    end else begin
      if (first_fetch) begin
        res_pc  <= cpu_addr;
        res_pbr <= cpu_bank;
      end
      if (wr_role == ROLE_FLAGS && !wr_hi) begin
        res_sp  <= cpu_addr;
        res_p   <= cpu_din;
        res_emu <= cpu_e;
      end
      if (wr_role == ROLE_ACC && !wr_hi)
        res_d <= cpu_addr - DP_OFS;
      if (wr_role == ROLE_XREG && !wr_hi)
        res_dbr <= cpu_bank;
    end
  end

  // One capture slice per stored register; only role and width pin differ.
  for (genvar g = 0; g < N_IREGS; g++) begin : g_ireg
    localparam wr_role_e MY_ROLE = (g == 0) ? ROLE_ACC :
                                   (g == 1) ? ROLE_XREG : ROLE_YREG;
    logic wide;
    assign wide = ~cpu_e & ~((g == 0) ? cpu_m : cpu_x);

    always_ff @(posedge clk) begin
      if (rst || arm) begin
        ireg[g] <= '0;
      end else if (wr_role == MY_ROLE) begin
        if (!wr_hi) begin
          ireg[g] <= {{DATA_W{1'b0}}, cpu_din};
        end else if (wide) begin
          ireg[g][REG_W-1:DATA_W] <= cpu_din;
        end
      end
    end
  end

  assign res_a = ireg[0];
  assign res_x = ireg[1];
  assign res_y = ireg[2];

endmodule

// File: rtl/regread_seq.sv
module regread_seq
  import regread_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_start,
  input  logic                cyc_vld,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [BANK_W-1:0]   cpu_bank,
  input  logic [DATA_W-1:0]   cpu_din,
  input  logic                cpu_rwb,
  input  logic                cpu_vpa,
  input  logic                cpu_vda,
  input  logic                cpu_e,
  input  logic                cpu_m,
  input  logic                cpu_x,
  output logic                ovr_en,
  output logic [DATA_W-1:0]   ovr_data,
  output logic                wr_inh,
  output logic                busy,
  output logic                done,
  output logic [ADDR_W-1:0]   res_pc,
  output logic [BANK_W-1:0]   res_pbr,
  output logic [ADDR_W-1:0]   res_sp,
  output logic [DATA_W-1:0]   res_p,
  output logic                res_emu,
  output logic [2*DATA_W-1:0] res_a,
  output logic [2*DATA_W-1:0] res_x,
  output logic [2*DATA_W-1:0] res_y,
  output logic [BANK_W-1:0]   res_dbr,
  output logic [ADDR_W-1:0]   res_d
);

  logic     arm, first_fetch, wr_hi;
  wr_role_e wr_role;

  regread_fetch_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .cmd_start   (cmd_start),
    .cyc_vld     (cyc_vld),
    .cpu_rwb     (cpu_rwb),
    .cpu_vpa     (cpu_vpa),
    .cpu_vda     (cpu_vda),
    .ovr_en      (ovr_en),
    .ovr_data    (ovr_data),
    .wr_inh      (wr_inh),
    .busy        (busy),
    .done        (done),
    .arm         (arm),
    .first_fetch (first_fetch),
    .wr_role     (wr_role),
    .wr_hi       (wr_hi)
  );

  regread_capture #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .arm         (arm),
    .first_fetch (first_fetch),
    .wr_role     (wr_role),
    .wr_hi       (wr_hi),
    .cpu_addr    (cpu_addr),
    .cpu_bank    (cpu_bank),
    .cpu_din     (cpu_din),
    .cpu_e       (cpu_e),
    .cpu_m       (cpu_m),
    .cpu_x       (cpu_x),
    .res_pc      (res_pc),
    .res_pbr     (res_pbr),
    .res_sp      (res_sp),
    .res_p       (res_p),
    .res_emu     (res_emu),
    .res_a       (res_a),
    .res_x       (res_x),
    .res_y       (res_y),
    .res_dbr     (res_dbr),
    .res_d       (res_d)
  );

endmodule

// File: rtl/regread_seq_chk.sv
module regread_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_start,
  input logic                cyc_vld,
  input logic                cpu_rwb,
  input logic                cpu_vpa,
  input logic                ovr_en,
  input logic [DATA_W-1:0]   ovr_data,
  input logic                wr_inh,
  input logic                busy,
  input logic                done,
  input logic [ADDR_W-1:0]   res_pc,
  input logic [ADDR_W-1:0]   res_sp,
  input logic [2*DATA_W-1:0] res_a,
  input logic [2*DATA_W-1:0] res_x,
  input logic [2*DATA_W-1:0] res_y
);

  // R2
  ovr_on_prog_read_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_en |-> (cyc_vld && cpu_vpa && cpu_rwb));

  // R3
  no_ovr_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !ovr_en);

  // R4
  inh_only_writes_chk: assert property (@(posedge clk) disable iff (rst)
    wr_inh |-> (!cpu_rwb && busy));

  // R10
  done_after_offset_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(ovr_en) && $past(ovr_data) == DATA_W'(8'hF5)));

  // R10
  results_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !cmd_start) |=> ($stable(res_pc) && $stable(res_sp) &&
                              $stable(res_a) && $stable(res_x) && $stable(res_y)));

  // R1
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

endmodule

bind regread_seq regread_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_regread_seq.sv
module tb_regread_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic        cyc_vld = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_bank = '0;
  logic [7:0]  cpu_din = '0;
  logic        cpu_rwb = 1'b1;
  logic        cpu_vpa = 1'b0;
  logic        cpu_vda = 1'b0;
  logic        cpu_e = 1'b1;
  logic        cpu_m = 1'b1;
  logic        cpu_x = 1'b1;
  logic        ovr_en, wr_inh, busy, done, res_emu;
  logic [7:0]  ovr_data, res_pbr, res_p, res_dbr;
  logic [15:0] res_pc, res_sp, res_a, res_x, res_y, res_d;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit poke = 1'b0;

  always #5 clk = ~clk;

  regread_seq dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One CPU bus cycle plus one idle clock; outputs compared on both clocks.
  task automatic bus(logic [15:0] a, logic [7:0] bk, logic [7:0] d, bit rw,
                     bit vpa, bit vda, bit exp_en, logic [7:0] exp_byte,
                     bit exp_inh, string req);
    @(negedge clk);
    cpu_addr = a; cpu_bank = bk; cpu_din = d; cpu_rwb = rw;
    cpu_vpa = vpa; cpu_vda = vda; cyc_vld = 1'b1;
    #1;
    chk({req, " ovr_en"}, 32'(ovr_en), 32'(exp_en));
    chk({req, " ovr_data"}, 32'(ovr_data), exp_en ? 32'(exp_byte) : 32'h0);
    chk("R4 wr_inh", 32'(wr_inh), 32'(exp_inh));
    @(negedge clk);
    cyc_vld = 1'b0; cpu_rwb = 1'b1; cpu_vpa = 1'b0; cpu_vda = 1'b0;
    cmd_start = poke;
    #1;
    chk("R3 idle ovr_en", 32'(ovr_en), 32'h0);
    chk("R4 idle wr_inh", 32'(wr_inh), 32'h0);
    cmd_start = 1'b0;
  endtask

  task automatic run_case(bit e, bit m, bit xf, logic [15:0] pc, logic [7:0] pbr,
                          logic [15:0] sp, logic [7:0] p, logic [15:0] a,
                          logic [15:0] xv, logic [15:0] yv, logic [7:0] dbr,
                          logic [15:0] dr, bit poke_mid);
    bit wa, wx;
    wa = !e && !m;
    wx = !e && !xf;
    cpu_e = e; cpu_m = m; cpu_x = xf;
    // free-running fetch before any command: untouched (R3)
    bus(pc - 16'd3, pbr, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R3 pre");
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    #1;
    chk("R1 busy", 32'(busy), 32'h1);
    chk("R1 done", 32'(done), 32'h0);
    // PHP
    bus(pc, pbr, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h08, 1'b0, "R2 php");
    bus(pc + 16'd1, pbr, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R3 io");
    bus(sp, 8'h00, p, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R6 push");
    // PLP
    bus(pc + 16'd1, pbr, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h28, 1'b0, "R2 plp");
    bus(pc + 16'd2, pbr, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R3 io");
    poke = poke_mid;
    bus(pc + 16'd2, pbr, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R3 io");
    poke = 1'b0;
    bus(sp, 8'h00, 8'hAA, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R3 pull");
    // STA dp
    bus(pc + 16'd2, pbr, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h85, 1'b0, "R2 sta");
    bus(pc + 16'd3, pbr, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h02, 1'b0, "R2 sta op");
    if (dr[7:0] != 8'h00)
      bus(pc + 16'd3, pbr, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R3 io");
    bus(dr + 16'd2, 8'h00, a[7:0], 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R7 wr");
    if (wa) bus(dr + 16'd3, 8'h00, a[15:8], 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R7 wr");
    // STX abs
    bus(pc + 16'd4, pbr, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h8E, 1'b0, "R2 stx");
    bus(pc + 16'd5, pbr, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h40, 1'b0, "R2 stx op");
    bus(pc + 16'd6, pbr, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h44, 1'b0, "R2 stx op");
    bus(16'h4440, dbr, xv[7:0], 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R8 wr");
    if (wx) bus(16'h4441, dbr, xv[15:8], 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R8 wr");
    // STY dp
    bus(pc + 16'd7, pbr, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h84, 1'b0, "R2 sty");
    bus(pc + 16'd8, pbr, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h06, 1'b0, "R2 sty op");
    if (dr[7:0] != 8'h00)
      bus(pc + 16'd8, pbr, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R3 io");
    bus(dr + 16'd6, 8'h00, yv[7:0], 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R9 wr");
    if (wx) bus(dr + 16'd7, 8'h00, yv[15:8], 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R9 wr");
    // BRA -11
    bus(pc + 16'd9, pbr, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h80, 1'b0, "R2 bra");
    bus(pc + 16'd10, pbr, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'hF5, 1'b0, "R2 bra op");
    chk("R10 done", 32'(done), 32'h1);
    chk("R10 busy", 32'(busy), 32'h0);
    bus(pc + 16'd10, pbr, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R3 io");
    // back at the original PC: real opcode, not overridden
    bus(pc, pbr, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R3 post");
    // a genuine program write after done: not inhibited, not captured
    bus(dr + 16'd2, 8'h00, 8'h5C, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R4 post");
    bus(16'h4440, 8'h7E, 8'h3D, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R4 post");
    chk("R5 pc", 32'(res_pc), 32'(pc));
    chk("R5 pbr", 32'(res_pbr), 32'(pbr));
    chk("R6 sp", 32'(res_sp), 32'(sp));
    chk("R6 p", 32'(res_p), 32'(p));
    chk("R6 emu", 32'(res_emu), 32'(e));
    chk("R7 a", 32'(res_a), wa ? 32'(a) : 32'(a[7:0]));
    chk("R7 d", 32'(res_d), 32'(dr));
    chk("R8 x", 32'(res_x), wx ? 32'(xv) : 32'(xv[7:0]));
    chk("R8 dbr", 32'(res_dbr), 32'(dbr));
    chk("R9 y", 32'(res_y), wx ? 32'(yv) : 32'(yv[7:0]));
    chk("R10 done held", 32'(done), 32'h1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset busy", 32'(busy), 32'h0);
    chk("R1 reset done", 32'(done), 32'h0);
    chk("R1 reset pc", 32'(res_pc), 32'h0);
    chk("R1 reset a", 32'(res_a), 32'h0);
    chk("R1 reset ovr", 32'(ovr_en), 32'h0);
    rst = 1'b0;
    // emulation mode, all narrow
    run_case(1'b1, 1'b1, 1'b1, 16'hC123, 8'h00, 16'h01F3, 8'h34, 16'hBBCC,
             16'h1122, 16'h3344, 8'h00, 16'h0000, 1'b0);
    // native, all wide, nonzero direct low byte, stray start mid-run (R10)
    run_case(1'b0, 1'b0, 1'b0, 16'h8000, 8'h12, 16'h1FFE, 8'h05, 16'hA55A,
             16'hBEEF, 16'hCAFE, 8'h7E, 16'h2310, 1'b1);
    // native, 8-bit A, 16-bit index
    run_case(1'b0, 1'b1, 1'b0, 16'h0200, 8'h01, 16'h0100, 8'h20, 16'h9988,
             16'h7766, 16'h5544, 8'h02, 16'h0000, 1'b0);
    // native, 16-bit A, 8-bit index
    run_case(1'b0, 1'b0, 1'b1, 16'hFFF0, 8'hFE, 16'h7FFF, 8'h10, 16'h1234,
             16'h5678, 16'h9ABC, 8'hFF, 16'hFF00, 1'b0);
    summary();
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule